// File: doc/BRIEF.md
# Coin-Accepting Vend Controller

This block is the sequencing logic of a vending unit that takes two coin sizes, worth 5 and 10 units. Each accepted coin shows up as a single-cycle pulse on its own input. Once the credit reaches 15 units, the block issues a release strobe. If the last coin takes the credit to 20 units, it also issues a change strobe for 5 units. After either payout the credit returns to zero.

The `USE_MOORE` parameter selects one of two structures. The first is a three-state machine whose strobes are formed from the current state together with the incoming coin. Its strobes appear in the same cycle as the coin, so they are only meaningful just ahead of the sampling edge. The second is a five-state machine whose strobes come from the state alone. Its strobes appear one cycle after the coin, stay clean for the whole cycle, and during that payout cycle any coin input is disregarded. In both variants, a cycle in which both coin pulses are high is treated as if no coin were present.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the machine is forced to zero credit. In the next cycle both strobes are low. In the three-state variant the strobes are also held low during any cycle in which `rst` is high.
- R2: A coin that leaves the total credit below 15 units is added to the credit and produces no strobe.
- R3: A coin that takes the credit to exactly 15 units causes a one-cycle release strobe (`vend_o`=1, `change_o`=0) and clears the credit. The strobe is in the coin's cycle for the three-state variant and in the next cycle for the five-state variant.
- R4: A dime that arrives with a credit of 10 takes the credit to 20. It causes a one-cycle release strobe together with a change strobe (`vend_o`=1, `change_o`=1) and clears the credit. The timing is the same as in R3. `change_o` is never high without `vend_o`.
- R5: In a cycle with no coin pulse, the credit holds. In the three-state variant both strobes are low in that cycle.
- R6: A cycle in which `nickel_i` and `dime_i` are both high changes neither the credit nor the strobes.
- R7: In the five-state variant, each strobe lasts exactly one cycle. It depends only on the state, so it never follows a coin input within the same cycle.
- R8: In the five-state variant, the machine moves from the payout cycle to zero credit unconditionally. A coin pulse during that cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse per 5-unit coin |
| dime_i | input | 1 | One-cycle pulse per 10-unit coin |
| vend_o | output | 1 | Release strobe |
| change_o | output | 1 | 5-unit change strobe |

## Verification
In the three-state variant, a coin's result is due in the same cycle as the coin. The bench drives each coin just after a falling edge and reads both strobes one nanosecond later, before the next rising edge. In the five-state variant, the result is due one cycle later. Its check in each cycle therefore compares against the result the model computed for the previous cycle's coin, while the model also drops a coin that arrives during a payout cycle. Every sequence of four coin symbols (none, nickel, dime, both) is swept for both variants side by side. Each sequence ends with an idle cycle so that the last delayed strobe is also checked.

// File: rtl/vend_pkg.sv
package vend_pkg;
   typedef enum logic [1:0] {
      COIN_NONE = 2'd0,
      COIN_NICKEL = 2'd1,
      COIN_DIME = 2'd2
   } coin_e;

   // three-state structure: encoding fixed at 00/01/10, 11 unused
   typedef enum logic [1:0] {
      MLY_ZERO = 2'b00,
      MLY_FIVE = 2'b01,
      MLY_TEN  = 2'b10
   } mly_state_e;

   typedef enum logic [2:0] {
      MOR_ZERO    = 3'd0,
      MOR_FIVE    = 3'd1,
      MOR_TEN     = 3'd2,
      MOR_VEND    = 3'd3,
      MOR_VENDCHG = 3'd4
   } mor_state_e;

   typedef struct packed {
      logic vend;
      logic change;
   } payout_t;
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
   import vend_pkg::*;
(
   input  logic  nickel_i,
   input  logic  dime_i,
   output coin_e coin_o
);
   always_comb begin
      unique case ({dime_i, nickel_i})
         2'b01:   coin_o = COIN_NICKEL;
         2'b10:   coin_o = COIN_DIME;
         default: coin_o = COIN_NONE;
      endcase
   end
endmodule

// File: rtl/vend_mealy_core.sv
module vend_mealy_core
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  coin_e   coin_i,
   output payout_t pay_o
);
   mly_state_e state_q, state_d;
   payout_t    pay_raw;

   always_ff @(posedge clk) begin
      if (rst) state_q <= MLY_ZERO;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      pay_raw = '0;
      unique case (state_q)
         MLY_ZERO: begin
            if (coin_i == COIN_NICKEL)    state_d = MLY_FIVE;
            else if (coin_i == COIN_DIME) state_d = MLY_TEN;
         end
         MLY_FIVE: begin
            if (coin_i == COIN_NICKEL) state_d = MLY_TEN;
            else if (coin_i == COIN_DIME) begin
               state_d      = MLY_ZERO;
               pay_raw.vend = 1'b1;
            end
         end
         MLY_TEN: begin
            if (coin_i != COIN_NONE) begin
               state_d        = MLY_ZERO;
               pay_raw.vend   = 1'b1;
               pay_raw.change = (coin_i == COIN_DIME);
            end
         end
         default: state_d = MLY_ZERO;
      endcase
   end

   assign pay_o = rst ? '0 : pay_raw;
endmodule

// File: rtl/vend_moore_core.sv
module vend_moore_core
   import vend_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  coin_e   coin_i,
   output payout_t pay_o
);
   mor_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (rst) state_q <= MOR_ZERO;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MOR_ZERO: begin
            if (coin_i == COIN_NICKEL)    state_d = MOR_FIVE;
            else if (coin_i == COIN_DIME) state_d = MOR_TEN;
         end
         MOR_FIVE: begin
            if (coin_i == COIN_NICKEL)    state_d = MOR_TEN;
            else if (coin_i == COIN_DIME) state_d = MOR_VEND;
         end
         MOR_TEN: begin
            if (coin_i == COIN_NICKEL)    state_d = MOR_VEND;
            else if (coin_i == COIN_DIME) state_d = MOR_VENDCHG;
         end
         default: state_d = MOR_ZERO;
      endcase
   end

   always_comb begin
      pay_o = '0;
      if (state_q == MOR_VEND) pay_o.vend = 1'b1;
      if (state_q == MOR_VENDCHG) begin
         pay_o.vend   = 1'b1;
         pay_o.change = 1'b1;
      end
   end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
   import vend_pkg::*;
#(
   parameter int unsigned USE_MOORE = 0
)(
   input  logic clk,
   input  logic rst,
   input  logic nickel_i,
   input  logic dime_i,
   output logic vend_o,
   output logic change_o
);
   localparam bit MOORE_SEL = (USE_MOORE == 1);

   coin_e   coin;
   payout_t pay;

   if (USE_MOORE > 1) begin : g_param_bad
      $error("coin_vend_ctrl: USE_MOORE must be 0 or 1");
   end

   vend_coin_decode dec_i (
      .nickel_i (nickel_i),
      .dime_i   (dime_i),
      .coin_o   (coin)
   );

   if (MOORE_SEL) begin : g_moore
      vend_moore_core core_i (
         .clk    (clk),
         .rst    (rst),
         .coin_i (coin),
         .pay_o  (pay)
      );
   end else begin : g_mealy
      vend_mealy_core core_i (
         .clk    (clk),
         .rst    (rst),
         .coin_i (coin),
         .pay_o  (pay)
      );
   end

   assign vend_o   = pay.vend;
   assign change_o = pay.change;
endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk #(
   parameter int unsigned USE_MOORE = 0
)(
   input logic clk,
   input logic rst,
   input logic nickel_i,
   input logic dime_i,
   input logic vend_o,
   input logic change_o
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!vend_o && !change_o));

   // R4
   change_needs_vend_chk: assert property (@(posedge clk) disable iff (rst) change_o |-> vend_o);

   if (USE_MOORE == 1) begin : g_moore
      // R7
      strobe_single_chk: assert property (@(posedge clk) disable iff (rst) vend_o |=> !vend_o);
      // R8
      payout_then_zero_chk: assert property (@(posedge clk) disable iff (rst)
         vend_o |=> !vend_o && !change_o);
   end else begin : g_mealy
      // R1
      reset_gate_chk: assert property (@(posedge clk) rst |-> (!vend_o && !change_o));
      // R5
      idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
         (!nickel_i && !dime_i) |-> !vend_o);
      // R6
      both_ignored_chk: assert property (@(posedge clk) disable iff (rst)
         (nickel_i && dime_i) |-> (!vend_o && !change_o));
      // R4
      change_on_dime_chk: assert property (@(posedge clk) disable iff (rst)
         change_o |-> (dime_i && !nickel_i));
   end
endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk #(.USE_MOORE(USE_MOORE)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .nickel_i (nickel_i),
   .dime_i   (dime_i),
   .vend_o   (vend_o),
   .change_o (change_o)
);

// File: tb/coin_vend_ctrl_tb_top.sv
`timescale 1ns/1ps
module coin_vend_ctrl_tb_top;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic nickel = 1'b0;
   logic dime = 1'b0;
   logic vend_a, chg_a, vend_b, chg_b;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int ma_cr, mo_cr;
   bit mo_pv, mo_pc;
   int tot_va, tot_ca, tot_vb, tot_cb;
   int exp_va, exp_ca, exp_vb, exp_cb;

   always #2.5 clk = ~clk;

   coin_vend_ctrl #(.USE_MOORE(0)) dut_i (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
      .vend_o(vend_a), .change_o(chg_a));

   coin_vend_ctrl #(.USE_MOORE(1)) dut_m_i (
      .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime),
      .vend_o(vend_b), .change_o(chg_b));

   always @(posedge clk) if (!rst) begin
      tot_va += vend_a; tot_ca += chg_a;
      tot_vb += vend_b; tot_cb += chg_b;
   end

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got vend/change=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; nickel = 1'b1; dime = 1'b0;
      #1 check("R1 gate", {vend_a, chg_a}, 2'b00);
      @(negedge clk);
      rst = 1'b0; nickel = 1'b0; dime = 1'b0;
      #1 check("R1 three-state", {vend_a, chg_a}, 2'b00);
      check("R1 five-state", {vend_b, chg_b}, 2'b00);
      ma_cr = 0; mo_cr = 0; mo_pv = 0; mo_pc = 0;
   endtask

   // sym: 0 idle, 1 nickel, 2 dime, 3 both
   task automatic step(int sym);
      int val;
      bit ev, ec, nv, nc;
      string ra, rb;
      @(negedge clk);
      nickel = sym[0]; dime = sym[1];
      val = (sym == 1) ? 5 : (sym == 2) ? 10 : 0;
      ev = 0; ec = 0;
      if (val != 0) begin
         if (ma_cr + val >= 15) begin
            ev = 1; ec = (ma_cr + val == 20); ma_cr = 0;
         end else ma_cr += val;
      end
      ra = ec ? "R4" : ev ? "R3" : (sym == 3) ? "R6" : (sym == 0) ? "R5" : "R2";
      #1 check(ra, {vend_a, chg_a}, {ev, ec});
      rb = mo_pv ? "R7" : "R8/R5";
      check(rb, {vend_b, chg_b}, {mo_pv, mo_pc});
      exp_va += ev; exp_ca += ec;
      nv = 0; nc = 0;
      if (mo_pv) mo_cr = 0;
      else if (val != 0) begin
         if (mo_cr + val >= 15) begin
            nv = 1; nc = (mo_cr + val == 20); mo_cr = 0;
         end else mo_cr += val;
      end
      mo_pv = nv; mo_pc = nc;
      exp_vb += nv; exp_cb += nc;
   endtask

   initial begin
      tot_va = 0; tot_ca = 0; tot_vb = 0; tot_cb = 0;
      exp_va = 0; exp_ca = 0; exp_vb = 0; exp_cb = 0;
      for (int s = 0; s < 256; s++) begin
         do_reset();
         for (int k = 0; k < 4; k++) step((s >> (2 * k)) & 3);
         step(0);
      end
      // directed: nickel, nickel, nickel then coin during payout (R8)
      do_reset();
      step(1); step(1); step(1); step(2); step(2); step(0); step(0);
      // dime, dime, nickel
      do_reset();
      step(2); step(2); step(1); step(0); step(0);
      @(negedge clk);
      check("R3 release total three-state", 2'(tot_va == exp_va), 2'b01);
      check("R4 change total three-state", 2'(tot_ca == exp_ca), 2'b01);
      check("R3 release total five-state", 2'(tot_vb == exp_vb), 2'b01);
      check("R4 change total five-state", 2'(tot_cb == exp_cb), 2'b01);
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule